// File: doc/BRIEF.md
# SD Command Line Engine

This block is the host side of the single-wire command channel of an SD-style card bus. A client hands it a 6-bit command index, a 32-bit argument and the kind of reply it expects. The engine serialises a 48-bit token onto the line, most significant bit first. The token carries framing, a direction bit and a 7-bit CRC. The engine then releases the line and listens for the card.

A reply can be short (48 bits) or long (136 bits). The engine checks the reply's framing and, for short replies, its CRC. It presents the captured bits on a response stream together with three error flags. If no start bit arrives in the listening window, the engine returns a timeout reply instead. For commands that expect no reply, it goes straight back to idle.

The engine advances one line bit per clock. Bit-rate division belongs to the surrounding logic. The command side is a valid/ready sink: a command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high, and `cmd_ready` is high only while the engine is idle. The response side is a valid/ready source: once `rsp_valid` rises, the data and flags hold until `rsp_ready` is seen high. No new command is taken until that handshake completes, so the client stalls the engine by holding `rsp_ready` low.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted command appears as exactly 48 driven cycles (`cmd_oe` high), starting the cycle after acceptance. The first bit is 0, the last bit is 1, and bits go out most significant first.
- R2: In the token, bit 46 is 1 (host direction), bits 45:40 are the command index and bits 39:8 are the argument.
- R3: Token bits 7:1 are a CRC7 computed over bits 47:8. The CRC uses polynomial x^7+x^3+1 with a zero start value. For example, index 0 with argument 0 gives the token 48'h400000000095, and index 8 with argument 32'h1AA gives 48'h48000001AA87.
- R4: Reply kind 2'b00 means no reply. The engine is idle (`cmd_ready` high) the cycle after the last token bit, and `rsp_valid` stays low.
- R5: For the other kinds, `cmd_i` is sampled every clock, starting with the clock after the last token bit. A 0 within the first 64 samples starts capture. If all 64 samples are 1, the engine returns a reply with `rsp_timeout`=1, zero data and both error flags clear.
- R6: Kind 2'b01, and also 2'b11, expects a 48-bit reply. The 48 received bits appear in `rsp_data[47:0]`, with the upper bits zero. `rsp_crc_err` is set when bits 7:1 differ from the CRC7 of bits 47:8. The captured bits are presented either way.
- R7: Kind 2'b10 expects a 136-bit reply. The last 128 received bits appear in `rsp_data`, with the end bit in bit 0. `rsp_crc_err` stays 0.
- R8: `rsp_frame_err` is set when the received end bit is 0 or the received direction bit (the second bit) is 1.
- R9: `rsp_valid` rises two clocks after the sample of the reply's last bit, or of the 64th idle sample. It then holds with stable data and flags until `rsp_ready` is high, and the engine is idle on the next clock.
- R10: When not driving, `cmd_oe` is 0 and `cmd_o` is 1. `cmd_ready`, `cmd_oe` and `rsp_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on valid and ready |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_rsp_kind | input | 2 | 00 none, 01/11 short, 10 long |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Client takes the reply |
| rsp_data | output | 128 | Captured reply bits |
| rsp_timeout | output | 1 | No start bit in the window |
| rsp_crc_err | output | 1 | Short-reply CRC mismatch |
| rsp_frame_err | output | 1 | Bad end or direction bit |
| cmd_o | output | 1 | Line value while driving |
| cmd_oe | output | 1 | Line drive enable |
| cmd_i | input | 1 | Line value sampled from the card |

## Verification
The bench builds the engine with its default listening window of 64 samples. With that window, a start bit on the 64th sample and a 64-sample silence are both within reach, and both sides of the timeout edge are covered. The bench runs short and long replies with clean, corrupted-CRC, bad-end-bit and wrong-direction framing. It also holds back-pressure on the response stream and checks two known command tokens bit by bit.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int TOK_BITS  = 48;
  localparam int LONG_BITS = 136;
  localparam int BODY_BITS = 40;
  localparam int DATA_W    = 128;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_SHORT = 2'b01,
    RSP_LONG  = 2'b10,
    RSP_ALT   = 2'b11
  } rsp_kind_e;

  // one serial step of x^7 + x^3 + 1
  function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

  function automatic logic [TOK_BITS-1:0] build_token(input logic [5:0] idx,
                                                      input logic [31:0] arg);
    logic [BODY_BITS-1:0] body;
    logic [6:0] c;
    body = {2'b01, idx, arg};
    c = '0;
    for (int i = BODY_BITS - 1; i >= 0; i--) c = crc7_step(c, body[i]);
    return {body, c, 1'b1};
  endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       din,
  output logic [6:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= '0;
    else if (en)       crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdcmd_tx.sv
module sdcmd_tx #(
  parameter int BITS = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] token,
  output logic            line_o,
  output logic            line_oe,
  output logic            last
);
  localparam int CNT_W = $clog2(BITS);

  logic [BITS-1:0]  sreg;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sreg <= token;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      sreg <= {sreg[BITS-2:0], 1'b1};
      cnt  <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  assign line_o  = sreg[BITS-1];
  assign line_oe = busy;
  assign last    = busy && (cnt == CNT_W'(BITS - 1));
endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              long_in,
  input  logic              line_i,
  output logic              fin,
  output logic [DATA_W-1:0] data,
  output logic              crc_err,
  output logic              frame_err,
  output logic              timeout
);
  localparam int WCNT_W = $clog2(TIMEOUT + 1);
  localparam int BCNT_W = $clog2(LONG_BITS);
  localparam int SR_W   = DATA_W - 1;

  typedef enum logic [1:0] {RX_OFF, RX_WAIT, RX_BITS} rx_st_e;

  rx_st_e            st;
  logic [WCNT_W-1:0] wcnt;
  logic [BCNT_W-1:0] bcnt;
  logic [SR_W-1:0]   sreg;
  logic              long_q;
  logic              dir_q;
  logic [6:0]        crc;
  logic              crc_en;
  logic              last_bit;
  logic [DATA_W-1:0] full;

  assign crc_en   = (st == RX_WAIT && !line_i) ||
                    (st == RX_BITS && bcnt < BCNT_W'(BODY_BITS));
  assign last_bit = (st == RX_BITS) &&
                    (bcnt == (long_q ? BCNT_W'(LONG_BITS - 1) : BCNT_W'(TOK_BITS - 1)));
  assign full     = {sreg, line_i};

  sdcmd_crc7 i_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .en   (crc_en),
    .din  (line_i),
    .crc  (crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= RX_OFF;
      wcnt      <= '0;
      bcnt      <= '0;
      sreg      <= '0;
      long_q    <= 1'b0;
      dir_q     <= 1'b0;
      fin       <= 1'b0;
      data      <= '0;
      crc_err   <= 1'b0;
      frame_err <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        RX_OFF: begin
          if (start) begin
            st     <= RX_WAIT;
            wcnt   <= '0;
            sreg   <= '0;
            long_q <= long_in;
          end
        end
        RX_WAIT: begin
          if (!line_i) begin
            st   <= RX_BITS;
            bcnt <= BCNT_W'(1);
            sreg <= {sreg[SR_W-2:0], line_i};
          end else if (wcnt == WCNT_W'(TIMEOUT - 1)) begin
            st        <= RX_OFF;
            fin       <= 1'b1;
            timeout   <= 1'b1;
            data      <= '0;
            crc_err   <= 1'b0;
            frame_err <= 1'b0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        RX_BITS: begin
          sreg <= {sreg[SR_W-2:0], line_i};
          bcnt <= bcnt + 1'b1;
          if (bcnt == BCNT_W'(1)) dir_q <= line_i;
          if (last_bit) begin
            st        <= RX_OFF;
            fin       <= 1'b1;
            timeout   <= 1'b0;
            data      <= long_q ? full : {{(DATA_W - TOK_BITS){1'b0}}, full[TOK_BITS-1:0]};
            frame_err <= !line_i || dir_q;
            crc_err   <= !long_q && (crc != full[7:1]);
          end
        end
        default: st <= RX_OFF;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [5:0]        cmd_index,
  input  logic [31:0]       cmd_arg,
  input  logic [1:0]        cmd_rsp_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_timeout,
  output logic              rsp_crc_err,
  output logic              rsp_frame_err,
  output logic              cmd_o,
  output logic              cmd_oe,
  input  logic              cmd_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_LISTEN, ST_HOLD} eng_st_e;

  eng_st_e   state;
  rsp_kind_e kind_q;
  logic      accept;
  logic      tx_o, tx_oe, tx_last;
  logic      rx_start, rx_fin;

  assign accept   = (state == ST_IDLE) && cmd_valid;
  assign rx_start = (state == ST_SEND) && tx_last && (kind_q != RSP_NONE);

  sdcmd_tx #(.BITS(TOK_BITS)) i_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .token  (build_token(cmd_index, cmd_arg)),
    .line_o (tx_o),
    .line_oe(tx_oe),
    .last   (tx_last)
  );

  sdcmd_rx #(.TIMEOUT(TIMEOUT)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (rx_start),
    .long_in  (kind_q == RSP_LONG),
    .line_i   (cmd_i),
    .fin      (rx_fin),
    .data     (rsp_data),
    .crc_err  (rsp_crc_err),
    .frame_err(rsp_frame_err),
    .timeout  (rsp_timeout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= RSP_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_SEND;
          kind_q <= rsp_kind_e'(cmd_rsp_kind);
        end
        ST_SEND:   if (tx_last) state <= (kind_q == RSP_NONE) ? ST_IDLE : ST_LISTEN;
        ST_LISTEN: if (rx_fin) state <= ST_HOLD;
        ST_HOLD:   if (rsp_ready) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_HOLD);
  assign cmd_oe    = tx_oe;
  assign cmd_o     = tx_oe ? tx_o : 1'b1;

  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_o);
  assert_end_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> $past(cmd_o));
  assert_dir_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |=> cmd_o);
  assert_timeout_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> (rsp_data == '0) && !rsp_crc_err && !rsp_frame_err);
  assert_long_no_crc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (kind_q == RSP_LONG) |-> !rsp_crc_err);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) &&
                                $stable(rsp_crc_err) && $stable(rsp_frame_err) &&
                                $stable(rsp_timeout));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_ready, cmd_oe, rsp_valid}));
endmodule

// File: tb/test_sd_cmd_engine.sv
`timescale 1ns/1ps
module test_sd_cmd_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [5:0]   cmd_index = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   cmd_rsp_kind = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [127:0] rsp_data;
  logic         rsp_timeout, rsp_crc_err, rsp_frame_err;
  logic         cmd_o, cmd_oe;
  logic         cmd_i = 1'b1;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sd_cmd_engine i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_rsp_kind(cmd_rsp_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err), .rsp_frame_err(rsp_frame_err),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference CRC7 by polynomial division of (body << 7) by 0x89
  function automatic logic [6:0] ref_crc(input logic [39:0] body);
    logic [46:0] m;
    m = {body, 7'b0};
    for (int i = 46; i >= 7; i--) if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    return m[6:0];
  endfunction

  function automatic logic [47:0] ref_token(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
  endfunction

  // check line and handshake pins for this cycle, then move one clock on
  task automatic cyc(input string tag, input logic eoe, input logic eo,
                     input logic erdy, input logic evld);
    chk({tag, " R10 cmd_oe"}, {127'b0, cmd_oe}, {127'b0, eoe});
    chk({tag, " R1 cmd_o"}, {127'b0, cmd_o}, {127'b0, eo});
    chk({tag, " R10 cmd_ready"}, {127'b0, cmd_ready}, {127'b0, erdy});
    chk({tag, " R9 rsp_valid"}, {127'b0, rsp_valid}, {127'b0, evld});
    @(negedge clk);
  endtask

  task automatic send_cmd(input string tag, input logic [5:0] idx, input logic [31:0] arg,
                          input logic [1:0] kind, input logic [47:0] tok);
    chk({tag, " R10 ready before issue"}, {127'b0, cmd_ready}, 128'd1);
    cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg; cmd_rsp_kind = kind;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_index = ~idx; cmd_arg = ~arg;
    for (int i = 0; i < 48; i++) cyc({tag, " R1 R2 R3 token"}, 1'b1, tok[47-i], 1'b0, 1'b0);
  endtask

  task automatic drive_rsp(input string tag, input int delay, input logic [135:0] bits,
                           input int nbits);
    for (int d = 0; d < delay; d++) begin
      cmd_i = 1'b1;
      cyc({tag, " R5 wait"}, 1'b0, 1'b1, 1'b0, 1'b0);
    end
    for (int i = 0; i < nbits; i++) begin
      cmd_i = bits[nbits-1-i];
      cyc({tag, " R5 reply"}, 1'b0, 1'b1, 1'b0, 1'b0);
    end
    cmd_i = 1'b1;
    cyc({tag, " R9 latency"}, 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic take_rsp(input string tag, input logic [127:0] edata, input logic eto,
                          input logic ecrc, input logic efrm, input int hold);
    for (int h = 0; h <= hold; h++) begin
      chk({tag, " R6 R7 rsp_data"}, rsp_data, edata);
      chk({tag, " R5 rsp_timeout"}, {127'b0, rsp_timeout}, {127'b0, eto});
      chk({tag, " R6 rsp_crc_err"}, {127'b0, rsp_crc_err}, {127'b0, ecrc});
      chk({tag, " R8 rsp_frame_err"}, {127'b0, rsp_frame_err}, {127'b0, efrm});
      if (h == hold) rsp_ready = 1'b1;
      cyc({tag, " R9 hold"}, 1'b0, 1'b1, 1'b0, 1'b1);
    end
    rsp_ready = 1'b0;
    cyc({tag, " R9 back to idle"}, 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  function automatic logic [47:0] short_rsp(input logic dir, input logic [37:0] content,
                                            input logic flip_crc, input logic endb);
    logic [6:0] c;
    c = ref_crc({1'b0, dir, content}) ^ {6'b0, flip_crc};
    return {1'b0, dir, content, c, endb};
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [47:0]  r;
    logic [135:0] lg;
    logic [126:0] pl;
    pl = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 31'h7EDCBA98};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset / idle state
    cyc("reset R10", 1'b0, 1'b1, 1'b1, 1'b0);

    // R3 known tokens, no reply expected (R4)
    send_cmd("known0 R3", 6'd0, 32'h0, 2'b00, 48'h400000000095);
    for (int k = 0; k < 4; k++) cyc("none R4", 1'b0, 1'b1, 1'b1, 1'b0);
    send_cmd("known8 R3", 6'd8, 32'h1AA, 2'b00, 48'h48000001AA87);
    cyc("none R4", 1'b0, 1'b1, 1'b1, 1'b0);

    // R6 clean short reply with back-pressure (R9)
    send_cmd("short R2", 6'd17, 32'h12345678, 2'b01, ref_token(6'd17, 32'h12345678));
    r = short_rsp(1'b0, {6'd17, 32'h00000900}, 1'b0, 1'b1);
    drive_rsp("short R6", 2, {88'b0, r}, 48);
    take_rsp("short R6", {80'b0, r}, 1'b0, 1'b0, 1'b0, 3);

    // R6 corrupted CRC, content still presented
    send_cmd("badcrc R2", 6'd13, 32'hA5A50F0F, 2'b01, ref_token(6'd13, 32'hA5A50F0F));
    r = short_rsp(1'b0, {6'd13, 32'hCAFEF00D}, 1'b1, 1'b1);
    drive_rsp("badcrc R6", 1, {88'b0, r}, 48);
    take_rsp("badcrc R6", {80'b0, r}, 1'b0, 1'b1, 1'b0, 0);

    // R8 end bit 0
    send_cmd("badend R1", 6'd55, 32'h0, 2'b01, ref_token(6'd55, 32'h0));
    r = short_rsp(1'b0, {6'd55, 32'h00000120}, 1'b0, 1'b0);
    drive_rsp("badend R8", 3, {88'b0, r}, 48);
    take_rsp("badend R8", {80'b0, r}, 1'b0, 1'b0, 1'b1, 0);

    // R8 direction bit 1, kind 2'b11 treated as short (R6)
    send_cmd("baddir R2", 6'd41, 32'h00FF8000, 2'b11, ref_token(6'd41, 32'h00FF8000));
    r = short_rsp(1'b1, {6'd63, 32'h80FF8000}, 1'b0, 1'b1);
    drive_rsp("baddir R8", 4, {88'b0, r}, 48);
    take_rsp("baddir R8", {80'b0, r}, 1'b0, 1'b0, 1'b1, 1);

    // R7 long reply
    send_cmd("long R2", 6'd2, 32'h0, 2'b10, ref_token(6'd2, 32'h0));
    lg = {2'b00, 6'h3F, pl, 1'b1};
    drive_rsp("long R7", 5, lg, 136);
    take_rsp("long R7", {pl, 1'b1}, 1'b0, 1'b0, 1'b0, 2);

    // R7 R8 long reply with end bit 0
    send_cmd("longend R2", 6'd9, 32'h00010000, 2'b10, ref_token(6'd9, 32'h00010000));
    lg = {2'b00, 6'h3F, ~pl, 1'b0};
    drive_rsp("longend R8", 2, lg, 136);
    take_rsp("longend R8", {~pl, 1'b0}, 1'b0, 1'b0, 1'b1, 0);

    // R5 start bit on the 64th sample: still captured
    send_cmd("edge63 R2", 6'd16, 32'h200, 2'b01, ref_token(6'd16, 32'h200));
    r = short_rsp(1'b0, {6'd16, 32'h00000900}, 1'b0, 1'b1);
    drive_rsp("edge63 R5", 63, {88'b0, r}, 48);
    take_rsp("edge63 R5", {80'b0, r}, 1'b0, 1'b0, 1'b0, 0);

    // R5 64 idle samples: timeout
    send_cmd("tmo R2", 6'd24, 32'h00001000, 2'b01, ref_token(6'd24, 32'h00001000));
    drive_rsp("tmo R5", 64, 136'b0, 0);
    take_rsp("tmo R5", 128'b0, 1'b1, 1'b0, 1'b0, 1);

    // R5 timeout window for a long reply, then normal traffic again
    send_cmd("tmolong R2", 6'd10, 32'h0, 2'b10, ref_token(6'd10, 32'h0));
    drive_rsp("tmolong R5", 64, 136'b0, 0);
    take_rsp("tmolong R5", 128'b0, 1'b1, 1'b0, 1'b0, 0);
    send_cmd("after R4", 6'd7, 32'hFFFFFFFF, 2'b00, ref_token(6'd7, 32'hFFFFFFFF));
    cyc("after R4", 1'b0, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
    report();
  end
endmodule